// File: doc/BRIEF.md
# UART FIFO Serial-Bypass Port

This block lets a local subsystem move bytes straight into and out of a UART's FIFOs through one parallel register address, with no serializer or deserializer involved. Bypass is in force only when the feature enable input and the bypass select bit of the subsystem control register are both 1. While it is in force, the port address has crossed directions. A subsystem write at that address loads the receive FIFO, as if the byte had arrived on the line. A subsystem read there drains the transmit FIFO, as if the byte were being sent.

When bypass is off, the serial receive engine feeds the receive FIFO and the serial transmit engine drains the transmit FIFO, and the port address does nothing. The block also gates the three line-error interrupt sources (parity, framing, break) that the serial receiver reports. They are forwarded when bypass is off and held at zero while bypass is on. The FIFOs are external and seen through push/pop strobes, a full flag, an empty flag and a show-ahead head byte. Every output is registered. The asynchronous active-low reset is released through an internal synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `uart_fifo_bypass`

## Requirements
- R1: Bypass is active only while both `feat_en` and `ctrl_bypass` are 1. With either one at 0, port accesses behave as in R6.
- R2: In bypass, the rising edge of `bus_wr` with `bus_addr` = 0x140 and `rxf_full` = 0 gives `rxf_push` = 1 for exactly one cycle, in the cycle after the clock edge that samples the rise, with `rxf_wdata` equal to `bus_wdata`.
- R3: In bypass, the rising edge of `bus_rd` with `bus_addr` = 0x140 and `txf_empty` = 0 gives `txf_pop` = 1 for one cycle, with the same one-cycle latency, and `bus_rdata` equal to the `txf_rdata` value sampled on that edge. `bus_rdata` then holds until the next bypass read.
- R4: A bypass write while `rxf_full` = 1 produces no push.
- R5: A bypass read while `txf_empty` = 1 produces no pop and sets `bus_rdata` to 0x00.
- R6: With bypass inactive, or at any other address, bus accesses cause no push and no pop and leave `bus_rdata` unchanged.
- R7: Holding `bus_wr` or `bus_rd` high for several cycles produces only one push or pop for that access.
- R8: In bypass, `ser_rx_valid` pushes nothing, and `ser_tx_req` pops nothing and leaves `ser_tx_valid` at 0.
- R9: With bypass inactive, a one-cycle `ser_rx_valid` with `rxf_full` = 0 pushes `ser_rx_data` one cycle later. A one-cycle `ser_tx_req` with `txf_empty` = 0 pops one byte one cycle later and presents it on `ser_tx_data` with `ser_tx_valid` = 1 for that cycle.
- R10: `line_err_irq` bit 0 is parity, bit 1 is framing and bit 2 is break. One cycle after a `ser_rx_valid` cycle, it equals `ser_rx_err` when bypass is inactive and 0 when it is active. In all other cycles it is 0.
- R11: During reset and right after it, `rxf_push`, `txf_pop`, `ser_tx_valid`, `line_err_irq` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Bypass feature enable |
| ctrl_bypass | input | 1 | Bypass select bit of the subsystem control register |
| bus_addr | input | 9 | Subsystem bus address |
| bus_wr | input | 1 | Subsystem write strobe (level, one access per rise) |
| bus_rd | input | 1 | Subsystem read strobe (level, one access per rise) |
| bus_wdata | input | 8 | Subsystem write data |
| bus_rdata | output | 8 | Byte returned by the last bypass read |
| ser_rx_valid | input | 1 | Serial receiver has a byte (one-cycle pulse) |
| ser_rx_data | input | 8 | Byte from the serial receiver |
| ser_rx_err | input | 3 | Line errors of that byte: {break, framing, parity} |
| ser_tx_req | input | 1 | Serial transmitter requests a byte (one-cycle pulse) |
| ser_tx_valid | output | 1 | Byte handed to the serial transmitter |
| ser_tx_data | output | 8 | Byte for the serial transmitter |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_push | output | 1 | Receive FIFO push strobe |
| rxf_wdata | output | 8 | Receive FIFO push data |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_rdata | input | 8 | Transmit FIFO head byte (show-ahead) |
| txf_pop | output | 1 | Transmit FIFO pop strobe |
| line_err_irq | output | 3 | Filtered line-error interrupt events |

## Verification
The port is driven with directed cases and with seeded random mixes of bus writes and reads, serial receive and transmit events, enable-bit combinations, addresses and FIFO levels. The cases where only one of the two enable bits is set separate a correct AND of the two bits from designs that look at only one of them. Reads from a loaded transmit FIFO, an empty one and a bypass-off port show whether the byte and the 0x00 default come from the right place. Held strobes, a full receive FIFO and serial traffic while bypass is on show whether a push or pop happens where none is allowed, and serial errors in both modes show whether the interrupt mask follows the mode.

// File: rtl/ufb_pkg.sv
package ufb_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LINE_ERR_N = 3;

  // Which source owns the receive-FIFO push in a given cycle
  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_BUS    = 2'd1,
    SRC_SERIAL = 2'd2
  } rx_src_e;

endpackage

// File: rtl/ufb_rst_sync.sv
module ufb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_n_s = shift_q[STAGES-1];

endmodule

// File: rtl/ufb_access_decode.sv
module ufb_access_decode #(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned PORT_ADDR = 32'h140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              ctrl_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              byp_act,
  output logic              wr_req,
  output logic              rd_req
);

  localparam int unsigned N_STB = 2;
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(PORT_ADDR);

  logic [N_STB-1:0] stb_in;
  logic [N_STB-1:0] stb_rise;
  logic             addr_hit;

  assign stb_in = {bus_rd, bus_wr};

  // One edge detector per strobe: an access is the low-to-high transition
  for (genvar i = 0; i < N_STB; i++) begin : g_edge
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d = stb_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
      end else begin
        prev_q <= prev_d;
      end
    end

    assign stb_rise[i] = stb_in[i] & ~prev_q;
  end

  assign byp_act  = feat_en & ctrl_sel;
  assign addr_hit = (bus_addr == HIT_ADDR);
  assign wr_req   = byp_act & addr_hit & stb_rise[0];
  assign rd_req   = byp_act & addr_hit & stb_rise[1];

endmodule

// File: rtl/ufb_path_sel.sv
module ufb_path_sel
  import ufb_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byp_act,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ser_rx_valid,
  input  logic [DATA_W-1:0] ser_rx_data,
  input  logic              ser_tx_req,
  input  logic              rxf_full,
  input  logic              txf_empty,
  input  logic [DATA_W-1:0] txf_rdata,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_wdata,
  output logic              txf_pop,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_tx_valid,
  output logic [DATA_W-1:0] ser_tx_data
);

  rx_src_e           rx_src;
  logic              bus_push_ok;
  logic              ser_push_ok;
  logic              bus_pop_ok;
  logic              ser_pop_ok;

  logic              push_d;
  logic              pop_d;
  logic              txv_d;
  logic              wdata_en;
  logic              rdata_en;
  logic              txd_en;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] txd_d;

  // Next-state logic
  always_comb begin
    bus_push_ok = wr_req & ~rxf_full;
    ser_push_ok = ~byp_act & ser_rx_valid & ~rxf_full;

    if (bus_push_ok) begin
      rx_src = SRC_BUS;
    end else if (ser_push_ok) begin
      rx_src = SRC_SERIAL;
    end else begin
      rx_src = SRC_IDLE;
    end

    push_d   = (rx_src != SRC_IDLE);
    wdata_en = push_d;
    unique case (rx_src)
      SRC_BUS:    wdata_d = bus_wdata;
      SRC_SERIAL: wdata_d = ser_rx_data;
      default:    wdata_d = rxf_wdata;
    endcase

    bus_pop_ok = rd_req & ~txf_empty;
    ser_pop_ok = ~byp_act & ser_tx_req & ~txf_empty;
    pop_d      = bus_pop_ok | ser_pop_ok;

    rdata_en = rd_req;
    rdata_d  = txf_empty ? '0 : txf_rdata;

    txv_d  = ser_pop_ok;
    txd_en = ser_pop_ok;
    txd_d  = txf_rdata;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_push     <= 1'b0;
      txf_pop      <= 1'b0;
      ser_tx_valid <= 1'b0;
      rxf_wdata    <= '0;
      bus_rdata    <= '0;
      ser_tx_data  <= '0;
    end else begin
      rxf_push     <= push_d;
      txf_pop      <= pop_d;
      ser_tx_valid <= txv_d;
      if (wdata_en) begin
        rxf_wdata <= wdata_d;
      end
      if (rdata_en) begin
        bus_rdata <= rdata_d;
      end
      if (txd_en) begin
        ser_tx_data <= txd_d;
      end
    end
  end

endmodule

// File: rtl/ufb_err_filter.sv
module ufb_err_filter #(
  parameter int unsigned ERR_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byp_act,
  input  logic             ser_rx_valid,
  input  logic [ERR_N-1:0] err_in,
  output logic [ERR_N-1:0] irq_out
);

  // One registered gate per error source; all share the bypass mask
  for (genvar i = 0; i < ERR_N; i++) begin : g_src
    logic ev_q;
    logic ev_d;

    always_comb begin
      ev_d = ser_rx_valid & err_in[i] & ~byp_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_q <= 1'b0;
      end else begin
        ev_q <= ev_d;
      end
    end

    assign irq_out[i] = ev_q;
  end

endmodule

// File: rtl/uart_fifo_bypass.sv
module uart_fifo_bypass
  import ufb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = BYTE_W,
  parameter int unsigned ERR_N       = LINE_ERR_N,
  parameter int unsigned PORT_ADDR   = 32'h140,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              ctrl_bypass,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ser_rx_valid,
  input  logic [DATA_W-1:0] ser_rx_data,
  input  logic [ERR_N-1:0]  ser_rx_err,
  input  logic              ser_tx_req,
  output logic              ser_tx_valid,
  output logic [DATA_W-1:0] ser_tx_data,
  input  logic              rxf_full,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_wdata,
  input  logic              txf_empty,
  input  logic [DATA_W-1:0] txf_rdata,
  output logic              txf_pop,
  output logic [ERR_N-1:0]  line_err_irq
);

  logic rst_n_s;
  logic byp_act;
  logic wr_req;
  logic rd_req;

  ufb_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  ufb_access_decode #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .feat_en  (feat_en),
    .ctrl_sel (ctrl_bypass),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .byp_act  (byp_act),
    .wr_req   (wr_req),
    .rd_req   (rd_req)
  );

  ufb_path_sel #(
    .DATA_W (DATA_W)
  ) u_path (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .byp_act      (byp_act),
    .wr_req       (wr_req),
    .rd_req       (rd_req),
    .bus_wdata    (bus_wdata),
    .ser_rx_valid (ser_rx_valid),
    .ser_rx_data  (ser_rx_data),
    .ser_tx_req   (ser_tx_req),
    .rxf_full     (rxf_full),
    .txf_empty    (txf_empty),
    .txf_rdata    (txf_rdata),
    .rxf_push     (rxf_push),
    .rxf_wdata    (rxf_wdata),
    .txf_pop      (txf_pop),
    .bus_rdata    (bus_rdata),
    .ser_tx_valid (ser_tx_valid),
    .ser_tx_data  (ser_tx_data)
  );

  ufb_err_filter #(
    .ERR_N (ERR_N)
  ) u_err (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .byp_act      (byp_act),
    .ser_rx_valid (ser_rx_valid),
    .err_in       (ser_rx_err),
    .irq_out      (line_err_irq)
  );

endmodule

// File: rtl/ufb_bypass_chk.sv
module ufb_bypass_chk #(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ERR_N     = 3,
  parameter int unsigned PORT_ADDR = 32'h140
) (
  input logic              clk,
  input logic              rst_n,
  input logic              feat_en,
  input logic              ctrl_bypass,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ser_rx_valid,
  input logic              ser_tx_valid,
  input logic              rxf_full,
  input logic              rxf_push,
  input logic              txf_empty,
  input logic              txf_pop,
  input logic [ERR_N-1:0]  line_err_irq
);

  logic       byp;
  logic       hit;
  logic [1:0] age_q;
  logic       rd_prev_q;

  assign byp = feat_en & ctrl_bypass;
  assign hit = (bus_addr == ADDR_W'(PORT_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q     <= 2'd0;
      rd_prev_q <= 1'b0;
    end else begin
      if (age_q != 2'd3) begin
        age_q <= age_q + 2'd1;
      end
      rd_prev_q <= bus_rd;
    end
  end

  // R4
  no_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && rxf_push) |-> !$past(rxf_full));

  // R5
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && txf_pop) |-> !$past(txf_empty));

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(byp && hit && bus_rd && !rd_prev_q && txf_empty))
      |-> (bus_rdata == '0));

  // R6
  push_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && rxf_push && !$past(!byp && ser_rx_valid))
      |-> $past(byp && hit && bus_wr));

  // R7
  one_push_per_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && rxf_push && $past(byp) && $past(byp, 2))
      |-> !$past(rxf_push));

  // R8
  no_serial_tx_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && ser_tx_valid) |-> !$past(byp));

  // R10
  err_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && line_err_irq != '0) |-> (!$past(byp) && $past(ser_rx_valid)));

endmodule

bind uart_fifo_bypass ufb_bypass_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .ERR_N     (ERR_N),
  .PORT_ADDR (PORT_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .feat_en      (feat_en),
  .ctrl_bypass  (ctrl_bypass),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .ser_rx_valid (ser_rx_valid),
  .ser_tx_valid (ser_tx_valid),
  .rxf_full     (rxf_full),
  .rxf_push     (rxf_push),
  .txf_empty    (txf_empty),
  .txf_pop      (txf_pop),
  .line_err_irq (line_err_irq)
);

// File: tb/uart_fifo_bypass_bench.sv
module uart_fifo_bypass_bench;

  localparam logic [8:0] PORT = 9'h140;

  logic       clk;
  logic       rst_n;
  logic       feat_en;
  logic       ctrl_bypass;
  logic [8:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ser_rx_valid;
  logic [7:0] ser_rx_data;
  logic [2:0] ser_rx_err;
  logic       ser_tx_req;
  logic       ser_tx_valid;
  logic [7:0] ser_tx_data;
  logic       rxf_full;
  logic       rxf_push;
  logic [7:0] rxf_wdata;
  logic       txf_empty;
  logic [7:0] txf_rdata;
  logic       txf_pop;
  logic [2:0] line_err_irq;

  int n_chk;
  int n_fail;
  bit done;

  // Transmit FIFO model
  logic [7:0] tq [0:15];
  int         tcnt;
  logic       load_req;
  logic [7:0] load_byte;
  logic [7:0] exp_rd;

  uart_fifo_bypass u_uart_fifo_bypass (
    .clk          (clk),
    .rst_n        (rst_n),
    .feat_en      (feat_en),
    .ctrl_bypass  (ctrl_bypass),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ser_rx_valid (ser_rx_valid),
    .ser_rx_data  (ser_rx_data),
    .ser_rx_err   (ser_rx_err),
    .ser_tx_req   (ser_tx_req),
    .ser_tx_valid (ser_tx_valid),
    .ser_tx_data  (ser_tx_data),
    .rxf_full     (rxf_full),
    .rxf_push     (rxf_push),
    .rxf_wdata    (rxf_wdata),
    .txf_empty    (txf_empty),
    .txf_rdata    (txf_rdata),
    .txf_pop      (txf_pop),
    .line_err_irq (line_err_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign txf_empty = (tcnt == 0);
  assign txf_rdata = tq[0];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= 0;
      for (int k = 0; k < 16; k++) tq[k] <= 8'h00;
    end else if (txf_pop && tcnt > 0) begin
      for (int k = 0; k < 15; k++) tq[k] <= tq[k+1];
      tcnt <= tcnt - 1;
    end else if (load_req && tcnt < 16) begin
      tq[tcnt] <= load_byte;
      tcnt <= tcnt + 1;
    end
  end

  function automatic bit exp_byp(input logic f, input logic c);
    return f & c;
  endfunction

  function automatic string acc_tag(input logic f, input logic c, input logic [8:0] a,
                                    input bit blocked, input string ok_tag, input string blk_tag);
    if (f != c) return "R1";
    if (!(f & c) || a != PORT) return "R6";
    if (blocked) return blk_tag;
    return ok_tag;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tx_load(input logic [7:0] b);
    load_req  = 1'b1;
    load_byte = b;
    @(negedge clk);
    load_req  = 1'b0;
  endtask

  task automatic op_write(input logic [8:0] a, input logic [7:0] d, input int hold);
    bit    ep;
    string tg;
    ep = exp_byp(feat_en, ctrl_bypass) && a == PORT && !rxf_full;
    tg = acc_tag(feat_en, ctrl_bypass, a, rxf_full, "R2", "R4");
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    chk(rxf_push == ep, tg, rxf_push, ep);
    if (ep) chk(rxf_wdata == d, "R2", rxf_wdata, d);
    for (int h = 1; h < hold; h++) begin
      @(negedge clk);
      chk(rxf_push == 1'b0, "R7", rxf_push, 0);
    end
    bus_wr = 1'b0;
    @(negedge clk);
    chk(rxf_push == 1'b0, "R7", rxf_push, 0);
  endtask

  task automatic op_read(input logic [8:0] a, input int hold);
    bit    ep;
    bit    acc;
    string tg;
    acc = exp_byp(feat_en, ctrl_bypass) && a == PORT;
    ep  = acc && tcnt > 0;
    if (acc) exp_rd = (tcnt > 0) ? tq[0] : 8'h00;
    tg = acc_tag(feat_en, ctrl_bypass, a, tcnt == 0, "R3", "R5");
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    chk(txf_pop == ep, tg, txf_pop, ep);
    chk(bus_rdata == exp_rd, tg, bus_rdata, exp_rd);
    for (int h = 1; h < hold; h++) begin
      @(negedge clk);
      chk(txf_pop == 1'b0, "R7", txf_pop, 0);
      chk(bus_rdata == exp_rd, "R7", bus_rdata, exp_rd);
    end
    bus_rd = 1'b0;
    @(negedge clk);
    chk(txf_pop == 1'b0, "R7", txf_pop, 0);
  endtask

  task automatic op_ser_rx(input logic [7:0] d, input logic [2:0] e);
    bit         b;
    bit         ep;
    logic [2:0] ei;
    b  = exp_byp(feat_en, ctrl_bypass);
    ep = !b && !rxf_full;
    ei = b ? 3'b000 : e;
    ser_rx_valid = 1'b1; ser_rx_data = d; ser_rx_err = e;
    @(negedge clk);
    chk(rxf_push == ep, b ? "R8" : "R9", rxf_push, ep);
    if (ep) chk(rxf_wdata == d, "R9", rxf_wdata, d);
    chk(line_err_irq == ei, "R10", line_err_irq, ei);
    ser_rx_valid = 1'b0; ser_rx_err = 3'b000;
    @(negedge clk);
    chk(line_err_irq == 3'b000, "R10", line_err_irq, 0);
    chk(rxf_push == 1'b0, "R9", rxf_push, 0);
  endtask

  task automatic op_ser_tx();
    bit         b;
    bit         ep;
    logic [7:0] hd;
    b  = exp_byp(feat_en, ctrl_bypass);
    ep = !b && tcnt > 0;
    hd = tq[0];
    ser_tx_req = 1'b1;
    @(negedge clk);
    chk(txf_pop == ep, b ? "R8" : "R9", txf_pop, ep);
    chk(ser_tx_valid == ep, b ? "R8" : "R9", ser_tx_valid, ep);
    if (ep) chk(ser_tx_data == hd, "R9", ser_tx_data, hd);
    ser_tx_req = 1'b0;
    @(negedge clk);
    chk(ser_tx_valid == 1'b0, "R9", ser_tx_valid, 0);
  endtask

  task automatic check_idle_outputs(input string tg);
    chk(rxf_push == 1'b0, tg, rxf_push, 0);
    chk(txf_pop == 1'b0, tg, txf_pop, 0);
    chk(ser_tx_valid == 1'b0, tg, ser_tx_valid, 0);
    chk(line_err_irq == 3'b000, tg, line_err_irq, 0);
    chk(bus_rdata == 8'h00, tg, bus_rdata, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete in time");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    void'($urandom(32'h5eed_0140));
    rst_n = 1'b0;
    feat_en = 1'b0; ctrl_bypass = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    ser_rx_valid = 1'b0; ser_rx_data = '0; ser_rx_err = '0; ser_tx_req = 1'b0;
    rxf_full = 1'b0; load_req = 1'b0; load_byte = '0; exp_rd = 8'h00;

    repeat (3) @(negedge clk);
    check_idle_outputs("R11");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle_outputs("R11");

    // R1: only one enable bit set -> no bypass
    feat_en = 1'b1; ctrl_bypass = 1'b0;
    op_write(PORT, 8'hA5, 1);
    feat_en = 1'b0; ctrl_bypass = 1'b1;
    op_write(PORT, 8'h5A, 1);
    // R2: both set
    feat_en = 1'b1; ctrl_bypass = 1'b1;
    op_write(PORT, 8'h3C, 1);
    op_write(9'h141, 8'h11, 1);
    // R4: full receive FIFO
    rxf_full = 1'b1;
    op_write(PORT, 8'h77, 1);
    rxf_full = 1'b0;
    // R7: held write and read
    op_write(PORT, 8'hC3, 4);
    // R3 / R5: reads
    tx_load(8'h12); tx_load(8'h34); tx_load(8'h56);
    op_read(PORT, 1);
    op_read(PORT, 3);
    op_read(PORT, 1);
    op_read(PORT, 1);
    // R6: bypass off, loaded transmit FIFO untouched
    tx_load(8'h9E);
    feat_en = 1'b0;
    op_read(PORT, 1);
    op_write(PORT, 8'h44, 1);
    // R9 / R10: serial paths with bypass off
    op_ser_rx(8'h81, 3'b101);
    op_ser_tx();
    // R8 / R10: serial paths ignored while bypass on
    tx_load(8'h2B);
    feat_en = 1'b1;
    op_ser_rx(8'h82, 3'b111);
    op_ser_tx();
    op_read(PORT, 1);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int         op;
      logic [8:0] a;
      op          = $urandom_range(0, 4);
      feat_en     = ($urandom_range(0, 3) != 0);
      ctrl_bypass = ($urandom_range(0, 3) != 0);
      rxf_full    = ($urandom_range(0, 4) == 0);
      a           = ($urandom_range(0, 9) < 7) ? PORT : 9'($urandom_range(0, 511));
      case (op)
        0: op_write(a, 8'($urandom_range(0, 255)), $urandom_range(1, 3));
        1: op_read(a, $urandom_range(1, 3));
        2: op_ser_rx(8'($urandom_range(0, 255)), 3'($urandom_range(0, 7)));
        3: op_ser_tx();
        default: if (tcnt < 14) tx_load(8'($urandom_range(0, 255)));
      endcase
    end

    finish_run();
  end

endmodule